// File: doc/BRIEF.md
# Real-Mode Fetch Address Generator

This block forms the physical instruction fetch address of a processor core that runs in 16-bit segmented real mode. It holds three pieces of state: a visible code-segment selector, a hidden copy of that segment's base address, and a 16-bit instruction pointer. The fetch address it drives is the hidden base plus the instruction pointer, zero-extended to 32 bits.

After reset, the hidden base holds a value near the top of the 32-bit space, while the visible selector holds an ordinary real-mode value. As a result, the first fetches come from just below 4 GB. The first time the selector is loaded, the hidden base is rewritten to the selector times sixteen. From then on, addressing follows the normal real-mode rule. The base is only refreshed on a selector load; it is never recomputed from the selector on each fetch.

A wrap-enable input models the 1 MB wraparound of early machines. Once the selector has been reloaded, it clears address bit 20. Sequencing logic around the block drives the selector loads and the instruction pointer writes and increments.

Top module: `rm_fetch_addr_gen`

## Requirements
- R1: While reset is active, and after its release with no other input active, `cs_sel` is 0xF000, `ip_cur` is 0xFFF0 and `fetch_addr` is 0xFFFFFFF0.
- R2: Until the first selector load after reset, `fetch_addr` equals 0xFFFF0000 plus `ip_cur`, whatever the value of `cs_sel`.
- R3: A cycle with `seg_ld` high sets `cs_sel` to `seg_val` at the next clock edge. From then on, `fetch_addr` equals `cs_sel` shifted left by 4 plus `ip_cur`.
- R4: A selector load and an instruction pointer write in the same cycle take effect together, so the next address uses both new values.
- R5: `ip_inc` raises `ip_cur` by one at the next edge, modulo 65536 (0xFFFF is followed by 0x0000).
- R6: When `ip_wr` and `ip_inc` are both high, `ip_cur` takes `ip_val` and the increment is ignored.
- R7: With selector 0xFFFF, pointer 0xFFFF and `wrap_en` low, `fetch_addr` is 0x0010FFEF, the highest real-mode address.
- R8: After at least one selector load, `wrap_en` high forces `fetch_addr` bit 20 to zero (0xFFFF:0xFFFF gives 0x0000FFEF). The effect is combinational, in the same cycle.
- R9: Before the first selector load, `wrap_en` has no effect on `fetch_addr`.
- R10: In cycles without `seg_ld`, `cs_sel` and the hidden base keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| seg_ld | input | 1 | Strobe that loads the code-segment selector |
| seg_val | input | 16 | Selector value for a load |
| ip_wr | input | 1 | Instruction pointer write strobe |
| ip_val | input | 16 | Instruction pointer value for a write |
| ip_inc | input | 1 | Instruction pointer increment strobe |
| wrap_en | input | 1 | Forces address bit 20 to zero once the selector has been reloaded |
| cs_sel | output | 16 | Visible code-segment selector |
| ip_cur | output | 16 | Current instruction pointer |
| fetch_addr | output | 32 | Physical fetch address |

## Verification
The hardest condition to reach is the one where the visible selector and the hidden base disagree. It exists only between reset and the first selector load, so no later stimulus can recreate it. The stimulus therefore works through that window first: it steps and wraps the instruction pointer, and pulses `wrap_en`, all before any load. It then loads 0xF000, the selector value already visible, and shows that the address moves from near 4 GB down to just under 1 MB. Simultaneous load and write cycles then reach the 0x10FFEF ceiling, and `wrap_en` is applied against that value.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  localparam int unsigned SEL_W   = 16;
  localparam int unsigned IP_W    = 16;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned SHIFT   = 4;
  localparam int unsigned WRAP_BIT = SEL_W + SHIFT;

  localparam logic [SEL_W-1:0]  RST_SEL  = 16'hF000;
  localparam logic [IP_W-1:0]   RST_IP   = 16'hFFF0;
  localparam logic [ADDR_W-1:0] RST_BASE = 32'hFFFF_0000;
endpackage

// File: rtl/rmf_rst_sync.sv
module rmf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rmf_seg_unit.sv
module rmf_seg_unit
  import rmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_ld,
  input  logic [SEL_W-1:0]  seg_val,
  output logic [SEL_W-1:0]  sel_q,
  output logic [ADDR_W-1:0] base_q,
  output logic              norm_q
);
  logic [SEL_W-1:0]  sel_d;
  logic [ADDR_W-1:0] base_d;
  logic              norm_d;

  // The hidden base is computed once, at load time, and then held.
  always_comb begin
    sel_d  = seg_val;
    base_d = {{(ADDR_W-SEL_W-SHIFT){1'b0}}, seg_val, {SHIFT{1'b0}}};
    norm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= RST_SEL;
      base_q <= RST_BASE;
      norm_q <= 1'b0;
    end else if (seg_ld) begin
      sel_q  <= sel_d;
      base_q <= base_d;
      norm_q <= norm_d;
    end
  end
endmodule

// File: rtl/rmf_ip_unit.sv
module rmf_ip_unit
  import rmf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ip_wr,
  input  logic [IP_W-1:0] ip_val,
  input  logic            ip_inc,
  output logic [IP_W-1:0] ip_q
);
  logic [IP_W-1:0] ip_d;
  logic            ip_en;

  always_comb begin
    ip_en = ip_wr | ip_inc;
    if (ip_wr) ip_d = ip_val;
    else       ip_d = ip_q + {{(IP_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ip_q <= RST_IP;
    else if (ip_en) ip_q <= ip_d;
  end
endmodule

// File: rtl/rmf_addr_calc.sv
module rmf_addr_calc
  import rmf_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [IP_W-1:0]   ip,
  input  logic              norm,
  input  logic              wrap_en,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum  = base + {{(ADDR_W-IP_W){1'b0}}, ip};
    addr = sum;
    if (norm && wrap_en) addr[WRAP_BIT] = 1'b0;
  end
endmodule

// File: rtl/rm_fetch_addr_gen.sv
module rm_fetch_addr_gen
  import rmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_ld,
  input  logic [SEL_W-1:0]  seg_val,
  input  logic              ip_wr,
  input  logic [IP_W-1:0]   ip_val,
  input  logic              ip_inc,
  input  logic              wrap_en,
  output logic [SEL_W-1:0]  cs_sel,
  output logic [IP_W-1:0]   ip_cur,
  output logic [ADDR_W-1:0] fetch_addr
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] base_q;
  logic              norm_q;

  rmf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rmf_seg_unit u_seg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .seg_ld  (seg_ld),
    .seg_val (seg_val),
    .sel_q   (cs_sel),
    .base_q  (base_q),
    .norm_q  (norm_q)
  );

  rmf_ip_unit u_ip (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ip_wr  (ip_wr),
    .ip_val (ip_val),
    .ip_inc (ip_inc),
    .ip_q   (ip_cur)
  );

  rmf_addr_calc u_addr (
    .base    (base_q),
    .ip      (ip_cur),
    .norm    (norm_q),
    .wrap_en (wrap_en),
    .addr    (fetch_addr)
  );
endmodule

// File: rtl/rmf_checker.sv
module rmf_checker
  import rmf_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              seg_ld,
  input logic [SEL_W-1:0]  seg_val,
  input logic              ip_wr,
  input logic [IP_W-1:0]   ip_val,
  input logic              ip_inc,
  input logic              wrap_en,
  input logic [SEL_W-1:0]  cs_sel,
  input logic [IP_W-1:0]   ip_cur,
  input logic [ADDR_W-1:0] fetch_addr
);
  a_r3_sel_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_ld |=> cs_sel == $past(seg_val));

  a_r3_addr_after_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_ld ##1 !wrap_en |->
      fetch_addr == ({16'h0, cs_sel} << SHIFT) + {16'h0, ip_cur});

  a_r5_ip_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ip_inc && !ip_wr) |=> ip_cur == $past(ip_cur) + 16'd1);

  a_r6_ip_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ip_wr |=> ip_cur == $past(ip_val));

  a_r8_bit20_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_ld ##1 wrap_en |-> fetch_addr[WRAP_BIT] == 1'b0);

  a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !seg_ld |=> $stable(cs_sel));
endmodule

bind rm_fetch_addr_gen rmf_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .seg_ld     (seg_ld),
  .seg_val    (seg_val),
  .ip_wr      (ip_wr),
  .ip_val     (ip_val),
  .ip_inc     (ip_inc),
  .wrap_en    (wrap_en),
  .cs_sel     (cs_sel),
  .ip_cur     (ip_cur),
  .fetch_addr (fetch_addr)
);

// File: tb/tb_rm_fetch_addr_gen.sv
module tb_rm_fetch_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_ld, ip_wr, ip_inc, wrap_en;
  logic [15:0] seg_val, ip_val;
  logic [15:0] cs_sel, ip_cur;
  logic [31:0] fetch_addr;

  typedef struct {
    logic [31:0] addr;
    logic [15:0] sel;
    logic [15:0] ip;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  // Bench-side reference state
  logic [15:0] m_sel;
  logic [15:0] m_ip;
  logic [31:0] m_base;
  bit          m_norm;

  always #2 clk = ~clk;

  rm_fetch_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .seg_ld(seg_ld), .seg_val(seg_val),
    .ip_wr(ip_wr), .ip_val(ip_val), .ip_inc(ip_inc), .wrap_en(wrap_en),
    .cs_sel(cs_sel), .ip_cur(ip_cur), .fetch_addr(fetch_addr)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input bit ld, input logic [15:0] sv, input bit wr,
                      input logic [15:0] iv, input bit inc, input bit wr_en,
                      input string tag);
    exp_t e;
    @(negedge clk);
    seg_ld = ld; seg_val = sv; ip_wr = wr; ip_val = iv; ip_inc = inc; wrap_en = wr_en;
    if (ld) begin
      m_sel  = sv;
      m_base = {12'h0, sv, 4'h0};
      m_norm = 1;
    end
    if (wr)       m_ip = iv;
    else if (inc) m_ip = m_ip + 16'd1;
    e.addr = m_base + {16'h0, m_ip};
    if (m_norm && wr_en) e.addr[20] = 1'b0;
    e.sel = m_sel;
    e.ip  = m_ip;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: samples just after the edge that makes the queued result visible.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "fetch_addr", fetch_addr, e.addr);
        chk(e.tag, "cs_sel", {16'h0, cs_sel}, {16'h0, e.sel});
        chk(e.tag, "ip_cur", {16'h0, ip_cur}, {16'h0, e.ip});
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; seg_ld = 0; ip_wr = 0; ip_inc = 0; wrap_en = 0;
    seg_val = '0; ip_val = '0;
    m_sel = 16'hF000; m_ip = 16'hFFF0; m_base = 32'hFFFF_0000; m_norm = 0;
    repeat (3) @(negedge clk);
    chk("R1", "fetch_addr in reset", fetch_addr, 32'hFFFF_FFF0);
    chk("R1", "cs_sel in reset", {16'h0, cs_sel}, 32'h0000_F000);
    rst_n = 1;
    repeat (3) @(negedge clk);

    step(0, 16'h0, 0, 16'h0, 0, 0, "R1 idle after reset");
    step(0, 16'h0, 0, 16'h0, 0, 1, "R9 wrap_en before load");
    step(0, 16'h0, 1, 16'h1234, 0, 0, "R2 reset base plus ip");
    step(0, 16'h0, 0, 16'h0, 1, 0, "R5 increment");
    step(0, 16'h0, 1, 16'hFFFF, 0, 1, "R2 top of space, R9");
    step(0, 16'h0, 0, 16'h0, 1, 0, "R5 ip wraps to zero");
    step(0, 16'h0, 1, 16'h0010, 1, 0, "R6 write beats increment");
    step(0, 16'h0, 1, 16'hFFF0, 0, 0, "R2 before first load");
    step(1, 16'hF000, 0, 16'h0, 0, 0, "R3 load equal selector drops base");
    step(1, 16'h1000, 1, 16'h0010, 0, 0, "R4 load and write together");
    step(1, 16'hFFFF, 1, 16'hFFFF, 0, 0, "R7 highest address");
    step(0, 16'h0, 0, 16'h0, 0, 1, "R8 bit 20 cleared");
    step(0, 16'h0, 0, 16'h0, 0, 0, "R10 base held");
    step(0, 16'h0, 0, 16'h0, 1, 1, "R8 R5 ip wraps in normal mode");
    for (int i = 0; i < 24; i++) begin
      step(i % 5 == 0, 16'h0123 * i[15:0], i % 3 == 0, 16'h0F0F ^ i[15:0],
           i % 2 == 0, i % 4 == 1, "R3 R10 mixed sequence");
    end
    step(0, 16'h0, 0, 16'h0, 0, 0, "R10 final hold");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule